// File: doc/BRIEF.md
# Local-History Branch Direction Predictor with Small Target Buffer

This block predicts whether a conditional branch is taken and, when it is, where it goes. Every branch owns a short private record of its recent outcomes, chosen by the low bits of its address. That record selects one saturating counter in a table that all branches share. A small, fully tagged target buffer keeps the destinations of taken branches that recur. The buffer is filled by hardware when a taken outcome retires. An instruction can also install a chosen destination directly. A branch that carries an "easy" hint trains only the target buffer. It leaves the private histories and the shared counters alone.

The front end presents a fetch address on the lookup port. It reads back a combinational prediction together with the history and counter that produced it. Resolved branches come back on a valid/ready update stream. Software target writes arrive on a second valid/ready stream that is never stalled. Both streams write the same target buffer. A software write therefore wins the cycle and back-pressures the update stream. A sender holds its payload stable while valid is high and ready is low. A transfer happens in a cycle where valid and ready are both high. Its effect is visible to lookups from the following cycle.

Top module: `lhist_bpred`

## Requirements
- R1: After reset every history entry is 0, every counter holds 1, and the target buffer is empty. Any lookup then returns pred_hit=0, pred_taken=0, pred_ctr=1 and pred_hist=0.
- R2: The history table has 16 entries of 4 bits, selected by pc[3:0]. An accepted non-easy update shifts the entry left and writes the actual outcome into bit 0 (1 = taken).
- R3: The shared table has 16 two-bit counters, selected by the branch's 4-bit history as it was before the update. An accepted non-easy update raises the counter on taken and lowers it on not-taken, saturating at 3 and 0.
- R4: pred_taken is 1 exactly when the selected counter's bit 1 is 1 and the target buffer hits on lk_pc. pred_target is the stored target whenever pred_hit is 1.
- R5: The target buffer has 4 entries matched on the full address. A taken update whose address hits overwrites that entry's target. A taken update that misses allocates an entry. A not-taken update leaves the buffer unchanged.
- R6: Allocation follows a round-robin pointer that starts at entry 0 and advances once per allocation. The fifth distinct allocation therefore evicts the first one.
- R7: An accepted software write installs its target. If the address already has an entry, that entry is rewritten in place and nothing is evicted. Otherwise the write allocates through the same round-robin pointer.
- R8: An update with the easy hint set leaves the history and the counters unchanged. When taken, it still trains the target buffer as in R5.
- R9: tw_ready is always 1, and upd_ready equals the inverse of tw_valid. An update offered while a software write is present is not accepted and has no effect.
- R10: Branches whose pc[3:0] differ keep separate histories, but they read and train the same counter table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Lookup address |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | Target buffer hit on lk_pc |
| pred_target | output | 32 | Target from the buffer (valid when pred_hit) |
| pred_hist | output | 4 | History entry selected by lk_pc |
| pred_ctr | output | 2 | Counter selected by that history |
| upd_valid | input | 1 | Resolved-branch update offered |
| upd_ready | output | 1 | Update accepted this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | 32 | Actual target |
| upd_easy | input | 1 | Easy hint: skip history and counters |
| tw_valid | input | 1 | Software target write offered |
| tw_ready | output | 1 | Software write accepted (always 1) |
| tw_pc | input | 32 | Branch address to install |
| tw_target | input | 32 | Target to install |

## Verification
The bench drives counters into both rails and keeps pushing. A counter that wraps would flip its prediction from strongly taken to not taken, or the reverse. It fills the target buffer past four entries and looks for the oldest address to miss. A pointer that fails to advance, or that advances on an in-place rewrite, evicts the wrong entry. It rewrites an address that is already installed. A design that allocates a duplicate would lose a live entry. It sends easy-hinted and back-pressured updates and checks that neither moves a history or counter. It also trains one branch and reads a second branch with a different index. That branch must keep its own history but see the shared counter.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int PC_W   = 32;
  localparam int HIST_W = 4;
  localparam int HIST_N = 16;
  localparam int CTR_W  = 2;
  localparam int BTB_N  = 4;
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int N      = 16,
  parameter int HIST_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist
);
  logic [N-1:0][HIST_W-1:0] tab;

  assign rd_hist = tab[rd_idx];
  assign wr_hist = tab[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) tab <= '0;
    else if (wr_en) tab[wr_idx] <= {tab[wr_idx][HIST_W-2:0], wr_bit};
  end

  // R8 / R9: without a write strobe no history moves
  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tab));
endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table #(
  parameter int HIST_W = 4,
  parameter int CTR_W  = 2,
  localparam int N     = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic [CTR_W-1:0]  rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINI = CTR_W'(1);

  logic [N-1:0][CTR_W-1:0] tab;
  logic [CTR_W-1:0]        cur;

  assign rd_ctr = tab[rd_idx];
  assign cur    = tab[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) tab <= {N{CINI}};
    else if (wr_en) begin
      if (wr_taken && cur != CMAX)        tab[wr_idx] <= cur + 1'b1;
      else if (!wr_taken && cur != '0)    tab[wr_idx] <= cur - 1'b1;
    end
  end

  a_r3_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tab[wr_idx] == CMAX) |=> tab[$past(wr_idx)] == CMAX);
  a_r3_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tab[wr_idx] == '0) |=> tab[$past(wr_idx)] == '0);
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W   = 32,
  parameter int N      = 4,
  localparam int PTR_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);
  logic [N-1:0]            vld;
  logic [N-1:0][PC_W-1:0]  tag;
  logic [N-1:0][PC_W-1:0]  tgt;
  logic [PTR_W-1:0]        rr;
  logic [N-1:0]            rd_m, wr_m;
  logic [PTR_W-1:0]        wr_sel;
  logic                    wr_hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign rd_m[i] = vld[i] && tag[i] == rd_pc;
    assign wr_m[i] = vld[i] && tag[i] == wr_pc;
  end

  always_comb begin
    rd_tgt = '0;
    wr_sel = rr;
    for (int i = 0; i < N; i++) begin
      if (rd_m[i]) rd_tgt = tgt[i];
      if (wr_m[i]) wr_sel = PTR_W'(i);
    end
  end
  assign rd_hit = |rd_m;
  assign wr_hit = |wr_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      tag <= '0;
      tgt <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      vld[wr_sel] <= 1'b1;
      tag[wr_sel] <= wr_pc;
      tgt[wr_sel] <= wr_tgt;
      if (!wr_hit) rr <= (rr == PTR_W'(N - 1)) ? '0 : rr + 1'b1;
    end
  end

  // R7: an address never sits in two entries
  a_r7_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_m) <= 1);
endmodule

// File: rtl/lhist_bpred.sv
module lhist_bpred #(
  parameter int PC_W   = bp_pkg::PC_W,
  parameter int HIST_W = bp_pkg::HIST_W,
  parameter int HIST_N = bp_pkg::HIST_N,
  parameter int CTR_W  = bp_pkg::CTR_W,
  parameter int BTB_N  = bp_pkg::BTB_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_taken,
  output logic              pred_hit,
  output logic [PC_W-1:0]   pred_target,
  output logic [HIST_W-1:0] pred_hist,
  output logic [CTR_W-1:0]  pred_ctr,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_target,
  input  logic              upd_easy,
  input  logic              tw_valid,
  output logic              tw_ready,
  input  logic [PC_W-1:0]   tw_pc,
  input  logic [PC_W-1:0]   tw_target
);
  localparam int IDX_W = $clog2(HIST_N);

  logic              upd_fire, h_wr, b_wr;
  logic [HIST_W-1:0] old_hist;
  logic [PC_W-1:0]   b_pc, b_tgt;

  assign tw_ready  = 1'b1;
  assign upd_ready = !tw_valid;
  assign upd_fire  = upd_valid && upd_ready;
  assign h_wr      = upd_fire && !upd_easy;
  assign b_wr      = tw_valid || (upd_fire && upd_taken);
  assign b_pc      = tw_valid ? tw_pc : upd_pc;
  assign b_tgt     = tw_valid ? tw_target : upd_target;

  bp_hist_table #(.N(HIST_N), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_pc[IDX_W-1:0]), .rd_hist(pred_hist),
    .wr_en(h_wr), .wr_idx(upd_pc[IDX_W-1:0]), .wr_bit(upd_taken),
    .wr_hist(old_hist));

  bp_pattern_table #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_hist), .rd_ctr(pred_ctr),
    .wr_en(h_wr), .wr_idx(old_hist), .wr_taken(upd_taken));

  bp_target_buf #(.PC_W(PC_W), .N(BTB_N)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(lk_pc), .rd_hit(pred_hit), .rd_tgt(pred_target),
    .wr_en(b_wr), .wr_pc(b_pc), .wr_tgt(b_tgt));

  assign pred_taken = pred_ctr[CTR_W-1] && pred_hit;

  // R4: a taken prediction always carries a target
  a_r4_taken_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);
endmodule

// File: tb/sim_lhist_bpred.sv
module sim_lhist_bpred;
  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, upd_pc = 0, upd_target = 0, tw_pc = 0, tw_target = 0;
  logic upd_valid = 0, upd_taken = 0, upd_easy = 0, tw_valid = 0;
  logic pred_taken, pred_hit, upd_ready, tw_ready;
  logic [31:0] pred_target;
  logic [3:0] pred_hist;
  logic [1:0] pred_ctr;
  int n_chk = 0, n_bad = 0;

  logic [3:0]  mh [16];
  logic [1:0]  mp [16];
  logic        mv [4];
  logic [31:0] mtag [4], mtg [4];
  int          rr;

  always #2 clk = ~clk;

  lhist_bpred u0 (.clk, .rst_n, .lk_pc, .pred_taken, .pred_hit, .pred_target,
    .pred_hist, .pred_ctr, .upd_valid, .upd_ready, .upd_pc, .upd_taken,
    .upd_target, .upd_easy, .tw_valid, .tw_ready, .tw_pc, .tw_target);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic m_install(logic [31:0] pc, logic [31:0] t);
    for (int i = 0; i < 4; i++)
      if (mv[i] && mtag[i] == pc) begin mtg[i] = t; return; end
    mv[rr] = 1; mtag[rr] = pc; mtg[rr] = t; rr = (rr + 1) % 4;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin mh[i] = 0; mp[i] = 1; end
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mtag[i] = 0; mtg[i] = 0; end
    rr = 0;
  endtask

  task automatic upd(logic [31:0] pc, logic tk, logic [31:0] t, logic ez);
    logic [3:0] h;
    @(negedge clk);
    upd_pc = pc; upd_taken = tk; upd_target = t; upd_easy = ez; upd_valid = 1;
    @(negedge clk);
    upd_valid = 0;
    if (!ez) begin
      h = mh[pc[3:0]];
      if (tk && mp[h] != 3) mp[h] = mp[h] + 1;
      if (!tk && mp[h] != 0) mp[h] = mp[h] - 1;
      mh[pc[3:0]] = {h[2:0], tk};
    end
    if (tk) m_install(pc, t);
  endtask

  task automatic swr(logic [31:0] pc, logic [31:0] t);
    @(negedge clk);
    tw_pc = pc; tw_target = t; tw_valid = 1;
    @(negedge clk);
    tw_valid = 0;
    m_install(pc, t);
  endtask

  // compare a lookup against the requirement model
  task automatic look(string req, logic [31:0] pc);
    logic hit; logic [31:0] tg; logic [3:0] h;
    @(negedge clk);
    lk_pc = pc; #1;
    hit = 0; tg = 0; h = mh[pc[3:0]];
    for (int i = 0; i < 4; i++) if (mv[i] && mtag[i] == pc) begin hit = 1; tg = mtg[i]; end
    check(req, {pred_taken, pred_hit, pred_target, pred_hist, pred_ctr},
               {mp[h][1] & hit, hit, tg, h, mp[h]});
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); lk_pc = 32'h1234_5678; #1;
    check("R1 reset state", {pred_taken, pred_hit, pred_hist, pred_ctr}, {1'b0, 1'b0, 4'h0, 2'd1});
    check("R9 tw_ready", tw_ready, 1);
  endtask

  task automatic t_history();
    do_reset();
    upd(32'h0000_0043, 1, 32'h900, 0);
    upd(32'h0000_0043, 0, 32'h900, 0);
    upd(32'h0000_0043, 1, 32'h900, 0);
    @(negedge clk); lk_pc = 32'h0000_0043; #1;
    check("R2 history shift 101", pred_hist, 4'b0101);
    look("R2 history model", 32'h43);
    for (int i = 0; i < 3; i++) upd(32'h43, 1, 32'h900, 0);
    look("R2 history saturate window", 32'h43);
  endtask

  task automatic t_saturate();
    do_reset();
    // pc with index 5, keep hist 0 by not-taken, then 1111 by taken
    for (int i = 0; i < 4; i++) upd(32'h5, 0, 0, 0);
    @(negedge clk); lk_pc = 32'h5; #1;
    check("R3 counter floor 0", pred_ctr, 2'd0);
    for (int i = 0; i < 12; i++) upd(32'h5, 1, 32'hA0, 0);
    @(negedge clk); lk_pc = 32'h5; #1;
    check("R3 counter ceiling 3", pred_ctr, 2'd3);
    check("R4 strong taken with hit", {pred_taken, pred_target}, {1'b1, 32'hA0});
    upd(32'h5, 1, 32'hA0, 0);
    look("R3 no wrap at 3", 32'h5);
  endtask

  task automatic t_predict();
    do_reset();
    upd(32'h2000_0007, 1, 32'h3000, 0);
    @(negedge clk); lk_pc = 32'h2000_0007; #1;
    check("R4 hit but weak counter", {pred_hit, pred_taken, pred_ctr}, {1'b1, 1'b0, 2'd1});
    // train counter at hist 0 via another branch, lookup one with no hit
    upd(32'h9, 1, 32'h10, 1);
    upd(32'h8, 0, 0, 0); upd(32'h8, 0, 0, 0);
    look("R4 model", 32'h2000_0007);
    look("R4 miss never taken", 32'h7777_0000);
  endtask

  task automatic t_btb();
    do_reset();
    upd(32'h100, 1, 32'hAAA, 0);
    upd(32'h100, 1, 32'hBBB, 0);
    @(negedge clk); lk_pc = 32'h100; #1;
    check("R5 overwrite target", {pred_hit, pred_target}, {1'b1, 32'hBBB});
    upd(32'h200, 0, 32'hCCC, 0);
    @(negedge clk); lk_pc = 32'h200; #1;
    check("R5 not-taken no alloc", pred_hit, 0);
    look("R5 full tag differs in high bits", 32'h1100);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 5; i++) upd(32'h1000 + 32'(i) * 16, 1, 32'h50 + 32'(i), 0);
    @(negedge clk); lk_pc = 32'h1000; #1;
    check("R6 oldest evicted", pred_hit, 0);
    @(negedge clk); lk_pc = 32'h1040; #1;
    check("R6 newest present", {pred_hit, pred_target}, {1'b1, 32'h54});
    look("R6 second entry kept", 32'h1010);
  endtask

  task automatic t_sw();
    do_reset();
    for (int i = 0; i < 4; i++) swr(32'h4000 + 32'(i) * 4, 32'h700 + 32'(i));
    swr(32'h4008, 32'hDEAD);
    @(negedge clk); lk_pc = 32'h4008; #1;
    check("R7 sw rewrite in place", {pred_hit, pred_target}, {1'b1, 32'hDEAD});
    @(negedge clk); lk_pc = 32'h4000; #1;
    check("R7 rewrite evicts nothing", {pred_hit, pred_target}, {1'b1, 32'h700});
    swr(32'h5000, 32'h1);
    @(negedge clk); lk_pc = 32'h4000; #1;
    check("R7 new sw write uses round robin", pred_hit, 0);
  endtask

  task automatic t_easy();
    do_reset();
    upd(32'h0C, 1, 32'h80, 1);
    upd(32'h0C, 1, 32'h80, 1);
    @(negedge clk); lk_pc = 32'h0C; #1;
    check("R8 easy hist and ctr frozen", {pred_hist, pred_ctr}, {4'h0, 2'd1});
    check("R8 easy still fills buffer", {pred_hit, pred_target}, {1'b1, 32'h80});
  endtask

  task automatic t_backpressure();
    do_reset();
    @(negedge clk);
    upd_pc = 32'h2; upd_taken = 1; upd_target = 32'h66; upd_easy = 0; upd_valid = 1;
    tw_pc = 32'h6000; tw_target = 32'h77; tw_valid = 1;
    #1 check("R9 upd_ready low during sw write", upd_ready, 0);
    @(negedge clk);
    upd_valid = 0; tw_valid = 0;
    m_install(32'h6000, 32'h77);
    @(negedge clk); lk_pc = 32'h2; #1;
    check("R9 stalled update has no effect", {pred_hit, pred_hist, pred_ctr}, {1'b0, 4'h0, 2'd1});
    look("R9 sw write accepted", 32'h6000);
  endtask

  task automatic t_private();
    do_reset();
    for (int i = 0; i < 3; i++) upd(32'h100, 1, 32'h900, 0);
    @(negedge clk); lk_pc = 32'h204; #1;
    check("R10 other branch history private", pred_hist, 4'h0);
    check("R10 shared counter seen", pred_ctr, 2'd2);
    look("R10 trained branch", 32'h100);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_history();
    t_saturate();
    t_predict();
    t_btb();
    t_rr();
    t_sw();
    t_easy();
    t_backpressure();
    t_private();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule